// File: doc/BRIEF.md
# Composite Video Timing Generator

This block derives every raster timing signal for a 50 Hz, 312-line monochrome composite picture from one 8 MHz pixel clock. A single flat frame counter steps once per clock through every pixel slot of a frame. The low 9 bits give the position within a 512-clock line and the upper bits give the line number. Horizontal sync, vertical sync, the active-picture window and a pixel-fetch strobe are all decoded from those bit fields and registered.

A parallel-in, serial-out shifter takes an 8-bit pixel word from the video memory side whenever the fetch strobe is high. It then sends the word to the serial video output, most significant bit first. Outside the active window the output is held at black (0). The counter returns to zero from its last value in one synchronous step. Every bit clears on the same edge, so the low and high parts of the count never disagree.

Top module: `video_timing_gen`

## Requirements
- R1: `frame_pos` starts at 0 on the first clock after reset is released and increases by exactly one on every clock.
- R2: After `frame_pos` reads 159743 (312 lines of 512 clocks, minus one), the next clock returns it to 0. No intermediate value appears.
- R3: `hsync` is 1 exactly when the line position of the previous clock's count (`frame_pos[8:0]`) was in 0..37.
- R4: `vsync` is 1 exactly when the line number of the previous clock's count (`frame_pos[17:9]`) was in 0..3.
- R5: `active` is 1 exactly when the previous clock's count had line position 96..479 and line number 24..311.
- R6: `pix_load` is 1 exactly when the previous clock's count was inside the active window with line position bits [2:0] equal to 0.
- R7: The `pix_word` present during a cycle with `pix_load` high is captured at the end of that cycle. On the next 8 clocks `video_out` gives its bits 7 down to 0, one per clock.
- R8: `video_out` is 0 whenever the count from two clocks earlier lies outside the active window, whatever `pix_word` holds.
- R9: When `rst_n` is low at a clock edge, the block reads `frame_pos`=0, `hsync`=1, `vsync`=1, `active`=0, `pix_load`=0 and `video_out`=0 after that edge. This holds even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_word | input | 8 | Pixel word to serialise, sampled at the end of a `pix_load` cycle |
| frame_pos | output | 18 | Current frame counter value |
| hsync | output | 1 | Horizontal sync, active high, registered |
| vsync | output | 1 | Vertical sync, active high, registered |
| active | output | 1 | Active-picture window, registered |
| pix_load | output | 1 | Pixel fetch strobe |
| video_out | output | 1 | Serial pixel output, 0 = black |

## Verification
The bench runs one whole frame through the wrap with a pixel word that changes with the fetch position. A wrong bit order, a missed load or a word taken at the wrong position then shows up as a mismatch in the serial stream. A second stretch drives a constant all-ones word, with ones also present between loads. This separates correct window gating from a shifter that leaks stale or pending data onto the output in blanking. Reset is asserted in the middle of an active line, so clearing of the counter, the sync registers and the shifter is checked against a state that is not already zero. Every output is compared on every clock against a model built only from the requirements. The boundary positions 37/38, 95/96, 479/480, lines 3/4 and 23/24, and the wrap from 159743 are all covered by that comparison.

// File: rtl/vtg_pkg.sv
// Shared types and helpers for the video timing generator.
// Assumes: integer bounds fit in 32 bits.
package vtg_pkg;

    // Decoded raster flags for one pixel slot
    typedef struct packed {
        logic hs;
        logic vs;
        logic act;
        logic load;
    } vtg_flags_t;

    // True when lo <= v < hi_excl
    function automatic logic in_span(input int v, input int lo, input int hi_excl);
        return (v >= lo) && (v < hi_excl);
    endfunction

endpackage

// File: rtl/vtg_frame_counter.sv
// Flat frame counter: one step per clock, terminal count registered one
// cycle ahead so the wrap clears every bit on a single edge.
// Assumes: LAST >= 2, LAST < 2**CNT_W.
module vtg_frame_counter #(
    parameter int CNT_W = 18,
    parameter int LAST  = 159743
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] cnt_q;
    logic             tc_q;

    // Advance the count; the pre-decoded terminal flag forces the wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tc_q  <= 1'b0;
        end else begin
            tc_q  <= (cnt_q == CNT_W'(LAST - 1));
            cnt_q <= tc_q ? '0 : cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != CNT_W'(LAST)) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R1
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_W'(LAST)) |=> (cnt_q == '0)); // R2
    AST_TC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        tc_q |-> (cnt_q == CNT_W'(LAST))); // R2

endmodule

// File: rtl/vtg_sync_decode.sv
// Decodes sync, window and fetch strobe from the counter's bit fields and
// registers them, so every flag lags its counter value by one clock.
// Assumes: PIX_W is a power of two; window edges are multiples of PIX_W.
module vtg_sync_decode
    import vtg_pkg::*;
#(
    parameter int XW       = 9,
    parameter int YW       = 9,
    parameter int HS_LEN   = 38,
    parameter int VS_LINES = 4,
    parameter int AX0      = 96,
    parameter int AX1      = 480,
    parameter int AY0      = 24,
    parameter int AY1      = 312,
    parameter int PIX_W    = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XW+YW-1:0] cnt,
    output vtg_flags_t      flags
);

    localparam int PH_W = $clog2(PIX_W);

    logic [XW-1:0] x;
    logic [YW-1:0] y;
    vtg_flags_t    dec;
    vtg_flags_t    flags_q;

    assign x = cnt[XW-1:0];
    assign y = cnt[XW+YW-1:XW];

    // Combinational decode of the current slot
    always_comb begin
        dec.hs   = in_span(int'(x), 0, HS_LEN);
        dec.vs   = in_span(int'(y), 0, VS_LINES);
        dec.act  = in_span(int'(x), AX0, AX1) && in_span(int'(y), AY0, AY1);
        dec.load = dec.act && (x[PH_W-1:0] == '0);
    end

    // Register the flags; reset leaves both syncs asserted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '{hs: 1'b1, vs: 1'b1, act: 1'b0, load: 1'b0};
        end else begin
            flags_q <= dec;
        end
    end

    assign flags = flags_q;

    AST_LOAD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q.load |-> flags_q.act); // R6
    AST_VS_START_HS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q.vs) |-> flags_q.hs); // R4
    AST_SYNC_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q.hs || flags_q.vs) |-> !flags_q.act); // R5

endmodule

// File: rtl/vtg_pixel_shifter.sv
// Parallel-in serial-out pixel shifter, MSB first, output gated to black
// outside the active window (window flag delayed to match the load stage).
// Assumes: load_i arrives at most once every PIX_W clocks.
module vtg_pixel_shifter #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             act_i,
    input  logic [PIX_W-1:0] word_i,
    output logic             vid_o
);

    logic [PIX_W-1:0] sr_q;
    logic             act_d_q;

    // Load a new word on the strobe, otherwise shift toward the MSB
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load_i) begin
            sr_q <= word_i;
        end else begin
            sr_q <= {sr_q[PIX_W-2:0], 1'b0};
        end
    end

    // Align the window flag with the shifter stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_d_q <= 1'b0;
        end else begin
            act_d_q <= act_i;
        end
    end

    assign vid_o = sr_q[PIX_W-1] & act_d_q;

    AST_SHIFT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load_i) |-> (sr_q == $past(word_i))); // R7

endmodule

// File: rtl/video_timing_gen.sv
// Top of the composite video timing generator: flat frame counter,
// registered sync/window decode and the serial pixel shifter.
// Assumes: one pixel clock; rst_n synchronous, active low.
module video_timing_gen
    import vtg_pkg::*;
#(
    parameter int LINE_LOG2 = 9,
    parameter int LINES     = 312,
    parameter int HS_LEN    = 38,
    parameter int VS_LINES  = 4,
    parameter int AX0       = 96,
    parameter int AX1       = 480,
    parameter int AY0       = 24,
    parameter int PIX_W     = 8,
    localparam int ROW_W    = $clog2(LINES),
    localparam int CNT_W    = LINE_LOG2 + ROW_W,
    localparam int LAST     = LINES * (1 << LINE_LOG2) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] pix_word,
    output logic [CNT_W-1:0] frame_pos,
    output logic             hsync,
    output logic             vsync,
    output logic             active,
    output logic             pix_load,
    output logic             video_out
);

    logic [CNT_W-1:0] cnt;
    vtg_flags_t       flags;

    vtg_frame_counter #(.CNT_W(CNT_W), .LAST(LAST)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt)
    );

    vtg_sync_decode #(
        .XW(LINE_LOG2), .YW(ROW_W), .HS_LEN(HS_LEN), .VS_LINES(VS_LINES),
        .AX0(AX0), .AX1(AX1), .AY0(AY0), .AY1(LINES), .PIX_W(PIX_W)
    ) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt),
        .flags (flags)
    );

    vtg_pixel_shifter #(.PIX_W(PIX_W)) u_shf (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (flags.load),
        .act_i  (flags.act),
        .word_i (pix_word),
        .vid_o  (video_out)
    );

    assign frame_pos = cnt;
    assign hsync     = flags.hs;
    assign vsync     = flags.vs;
    assign active    = flags.act;
    assign pix_load  = flags.load;

    AST_VIDEO_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        video_out |-> $past(active)); // R8

endmodule

// File: tb/video_timing_gen_test.sv
module video_timing_gen_test;

    localparam int F = 159744;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pix_word = 8'hFF;
    logic [17:0] frame_pos;
    logic       hsync, vsync, active, pix_load, video_out;

    int total = 0;
    int bad   = 0;
    int mc    = 0;   // bench model of the counter
    int k     = 0;   // clocks since reset released
    int mode  = 0;

    always #2 clk = ~clk;

    video_timing_gen uut (
        .clk(clk), .rst_n(rst_n), .pix_word(pix_word), .frame_pos(frame_pos),
        .hsync(hsync), .vsync(vsync), .active(active), .pix_load(pix_load),
        .video_out(video_out)
    );

    // Independent model of position and clocks since reset
    always @(posedge clk) begin
        if (!rst_n) begin
            mc <= 0;
            k  <= 0;
        end else begin
            mc <= (mc == F - 1) ? 0 : mc + 1;
            if (k < 1000) k <= k + 1;
        end
    end

    function automatic int wrapm(input int v);
        return (v % F + F) % F;
    endfunction

    function automatic bit m_hs(input int p); return (p % 512) < 38; endfunction
    function automatic bit m_vs(input int p); return (p / 512) < 4; endfunction
    function automatic bit m_act(input int p);
        return (p % 512) >= 96 && (p % 512) < 480 && (p / 512) >= 24;
    endfunction

    function automatic logic [7:0] pat(input int p, input int md);
        if (md == 1) return 8'hFF;
        if (md == 2) return 8'h81;
        return 8'(p >> 3) ^ 8'h5A ^ 8'(p >> 11);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: compare every output with the model, then drive pix_word
    task automatic step();
        int p1, p2, wbase;
        bit ev;
        @(negedge clk);
        if (k == 0) begin
            chk(frame_pos == 0, "R9 frame_pos", frame_pos, 0);
            chk(hsync == 1 && vsync == 1, "R9 syncs", {hsync, vsync}, 3);
            chk(active == 0 && pix_load == 0 && video_out == 0, "R9 window/load/video",
                {active, pix_load, video_out}, 0);
        end else begin
            p1 = wrapm(mc - 1);
            p2 = wrapm(mc - 2);
            chk(int'(frame_pos) == mc, (mc == 0) ? "R2 wrap" : "R1 count", frame_pos, mc);
            chk(hsync == m_hs(p1), "R3 hsync", hsync, m_hs(p1));
            chk(vsync == m_vs(p1), "R4 vsync", vsync, m_vs(p1));
            chk(active == m_act(p1), "R5 active", active, m_act(p1));
            chk(pix_load == (m_act(p1) && (p1 % 8) == 0), "R6 pix_load", pix_load,
                m_act(p1) && (p1 % 8) == 0);
            if (k >= 2 && m_act(p2)) begin
                wbase = p2 - (p2 % 8);
                ev = pat(wbase, mode)[7 - (p2 % 8)];
                chk(video_out == ev, "R7 serial bit", video_out, ev);
            end else begin
                chk(video_out == 1'b0, "R8 blank video", video_out, 0);
            end
        end
        if (pix_load) pix_word = pat(int'(frame_pos) - 1, mode);
        else          pix_word = 8'hFF;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
    endtask

    task automatic t_full_frame();
        mode = 0;
        rst_n = 1'b1;
        repeat (F + 600) step();
    endtask

    task automatic t_mid_reset();
        mode = 2;
        repeat (12500 - 600) step();
        chk(active == 1'b1, "R9 precondition active", active, 1);
        rst_n = 1'b0;
        repeat (2) step();
        rst_n = 1'b1;
    endtask

    task automatic t_ones_after_reset();
        mode = 1;
        repeat (12900) step();
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_full_frame();
        t_mid_reset();
        t_ones_after_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule